// File: doc/BRIEF.md
# Resynchronizable Divide-by-32 Phase Marker

This block runs on the sample clock and keeps a modulo-32 phase counter that free-runs from reset. From the counter it derives a square marker of half duty whose rising edge falls on count 0. A shared alignment input is sampled on every clock. Only a low-to-high change of that sampled level returns the counter to phase 0. Several copies that see the same alignment edge on the same clock edge therefore emit the marker in identical phase. A downstream receiver can then pair sample n of one channel with sample n of the others.

The edge detector is a two-state machine. State `LVL_LOW` means the last sampled level was low, and state `LVL_HIGH` means it was high. The transition LOW-to-HIGH (input sampled high while in `LVL_LOW`) is the only one that fires the resync strobe. The transitions HIGH-to-LOW, LOW-hold and HIGH-hold fire nothing.

The marker shares its output pin with one bit of the incoming sample word. A single configuration bit, written through a write strobe and read back on a data port, picks the marker when set. The bit is clear after reset, so the pin then carries the sample bit.

Top module: `phase_sync_gen`

## Requirements
- R1: While reset is high and just after it, the configuration bit reads 0 and the pin carries bit `DATA_BIT` (default 3) of `sample_word`.
- R2: With no resync, the phase counter advances by one on each clock and wraps from 31 to 0.
- R3: When `sync_in` is sampled high on a clock edge and was sampled low on the edge before, the counter holds 0 after that edge.
- R4: A `sync_in` that stays high, or stays low, for any number of cycles causes no further resync.
- R5: With the configuration bit set, the pin is high while the count is 0 to 15 and low while it is 16 to 31.
- R6: Rising edges of `sync_in` spaced by a multiple of 32 cycles leave the marker waveform unchanged.
- R7: A clock edge with `cfg_we` high stores `cfg_wdata`. `cfg_rdata` shows the stored bit after that edge, and the pin source switches at the same edge.
- R8: With the configuration bit clear, the pin follows bit `DATA_BIT` of `sample_word` in the same cycle, whatever the counter does.
- R9: Reset clears the edge state to `LVL_LOW`, so a `sync_in` held high through reset release resyncs on the first edge after release.
- R10: Copies that were released from reset at different times and share `sync_in` show identical pin waveforms from the first shared rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Shared alignment input, already synchronous to `clk` |
| sample_word | input | SAMPLE_W | Current sample word; one bit can drive the pin |
| cfg_we | input | 1 | Write strobe for the configuration bit |
| cfg_wdata | input | 1 | Value written to the configuration bit |
| cfg_rdata | output | 1 | Stored configuration bit |
| pin_out | output | 1 | Phase marker when enabled, otherwise the selected sample bit |

## Verification
A resync edge and the natural wrap from 31 to 0 can fall on the same clock edge. Periodic alignment edges spaced by 32 and by 64 cycles put the reload exactly on the wrap, and the pin must stay identical to a free-running count. A configuration write can also land in the same cycle as an alignment edge. The random phase issues both with independent probabilities, and every cycle is judged against a per-copy reference model of the count, the level history and the enable.

// File: rtl/psg_pkg.sv
package psg_pkg;

    // Level seen on the previous sampling edge of the alignment input
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    // Pin source selection
    typedef enum logic {
        SRC_SAMPLE = 1'b0,
        SRC_MARKER = 1'b1
    } pin_src_t;

endpackage

// File: rtl/psg_edge_fsm.sv
module psg_edge_fsm
    import psg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise_o
);

    lvl_state_t state_q;
    lvl_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (sync_in) begin
                    state_d = LVL_HIGH;
                    rise_o  = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!sync_in) begin
                    state_d = LVL_LOW;
                end
            end
            default: begin
                state_d = LVL_LOW;
            end
        endcase
    end

    // R4: a held high level never produces a strobe
    p_hold_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == LVL_HIGH) |-> !rise_o);

endmodule

// File: rtl/psg_phase_ctr.sv
module psg_phase_ctr #(
    parameter int DIV        = 32,
    parameter int LOAD_PHASE = 0,
    parameter int PHASE_W    = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               resync_i,
    output logic [PHASE_W-1:0] count_o,
    output logic               mark_o
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(DIV - 1);
    localparam logic [PHASE_W-1:0] HALF = PHASE_W'(DIV / 2);
    localparam logic [PHASE_W-1:0] LOAD = PHASE_W'(LOAD_PHASE);
    localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] cnt_inc;

    generate
        if (POW2) begin : g_pow2
            assign cnt_inc = cnt_q + PHASE_W'(1);
        end else begin : g_cmp
            assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + PHASE_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (resync_i) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    assign count_o = cnt_q;
    assign mark_o  = (cnt_q < HALF);

    // R3: a resync strobe leaves the load phase behind it
    p_resync_load_r3: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (cnt_q == LOAD));

    // R2: wrap from the last count to zero
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!resync_i && cnt_q == LAST) |=> (cnt_q == '0));

    // R2: single step otherwise
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!resync_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + PHASE_W'(1)));

    // R5: marker rises only at count zero
    p_mark_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_o) |-> (cnt_q == '0));

endmodule

// File: rtl/psg_cfg_reg.sv
module psg_cfg_reg
    import psg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  logic     wdata_i,
    output logic     rdata_o,
    output pin_src_t src_o
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (we_i) begin
            en_q <= wdata_i;
        end
    end

    assign rdata_o = en_q;
    assign src_o   = en_q ? SRC_MARKER : SRC_SAMPLE;

    // R7: a write is visible on the read port after the edge
    p_write_back_r7: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (rdata_o == $past(wdata_i)));

    // R7: without a write the bit holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(rdata_o));

endmodule

// File: rtl/psg_pin_mux.sv
module psg_pin_mux
    import psg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DATA_BIT = 3
) (
    input  pin_src_t            src_i,
    input  logic                mark_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                pin_o
);

    always_comb begin
        unique case (src_i)
            SRC_MARKER: pin_o = mark_i;
            SRC_SAMPLE: pin_o = sample_i[DATA_BIT];
            default:    pin_o = sample_i[DATA_BIT];
        endcase
    end

endmodule

// File: rtl/phase_sync_gen.sv
module phase_sync_gen
    import psg_pkg::*;
#(
    parameter int DIV        = 32,
    parameter int SAMPLE_W   = 16,
    parameter int DATA_BIT   = 3,
    parameter int LOAD_PHASE = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_in,
    input  logic [SAMPLE_W-1:0] sample_word,
    input  logic                cfg_we,
    input  logic                cfg_wdata,
    output logic                cfg_rdata,
    output logic                pin_out
);

    localparam int PHASE_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic               rise;
    logic [PHASE_W-1:0] count;
    logic               mark;
    pin_src_t           src;

    psg_edge_fsm u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .rise_o  (rise)
    );

    psg_phase_ctr #(
        .DIV        (DIV),
        .LOAD_PHASE (LOAD_PHASE),
        .PHASE_W    (PHASE_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .resync_i (rise),
        .count_o  (count),
        .mark_o   (mark)
    );

    psg_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .src_o   (src)
    );

    psg_pin_mux #(
        .SAMPLE_W (SAMPLE_W),
        .DATA_BIT (DATA_BIT)
    ) u_mux (
        .src_i    (src),
        .mark_i   (mark),
        .sample_i (sample_word),
        .pin_o    (pin_out)
    );

    // R4: a level held across two edges gives no strobe
    p_level_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_in && $past(sync_in) && !$past(rst)) |-> !rise);

    // R3: a fresh low-to-high sample gives a strobe
    p_edge_fires_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_in && !$past(sync_in) && !$past(rst)) |-> rise);

    // R8: with the bit clear the pin tracks the selected sample bit
    p_sample_path_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata |-> (pin_out == sample_word[DATA_BIT]));

endmodule

// File: tb/phase_sync_gen_bench.sv
module phase_sync_gen_bench;

    localparam int DIV = 32;
    localparam int SW  = 16;
    localparam int DB  = 3;

    logic          clk = 1'b0;
    logic [2:0]    rst;
    logic          sync_in;
    logic [SW-1:0] sample;
    logic          cfg_we;
    logic          cfg_wd;
    logic [2:0]    pin;
    logic [2:0]    rd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_cnt  [3];
    bit m_prev [3];
    bit m_en   [3];

    always #4 clk = ~clk;

    phase_sync_gen #(.DIV(DIV), .SAMPLE_W(SW), .DATA_BIT(DB)) u_phase_sync_gen (
        .clk(clk), .rst(rst[0]), .sync_in(sync_in), .sample_word(sample),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wd), .cfg_rdata(rd[0]), .pin_out(pin[0]));

    phase_sync_gen #(.DIV(DIV), .SAMPLE_W(SW), .DATA_BIT(DB)) u_phase_sync_gen_1 (
        .clk(clk), .rst(rst[1]), .sync_in(sync_in), .sample_word(sample),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wd), .cfg_rdata(rd[1]), .pin_out(pin[1]));

    phase_sync_gen #(.DIV(DIV), .SAMPLE_W(SW), .DATA_BIT(DB)) u_phase_sync_gen_2 (
        .clk(clk), .rst(rst[2]), .sync_in(sync_in), .sample_word(sample),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wd), .cfg_rdata(rd[2]), .pin_out(pin[2]));

    // Reference model built from the requirements
    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst[i]) begin
                m_cnt[i]  = 0;
                m_prev[i] = 1'b0;
                m_en[i]   = 1'b0;
            end else begin
                if (sync_in && !m_prev[i]) m_cnt[i] = 0;
                else                       m_cnt[i] = (m_cnt[i] + 1) % DIV;
                m_prev[i] = sync_in;
                if (cfg_we) m_en[i] = cfg_wd;
            end
        end
    end

    function automatic logic exp_pin(int i);
        return m_en[i] ? logic'(m_cnt[i] < DIV / 2) : sample[DB];
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        #2;
        for (int i = 0; i < 3; i++) begin
            chk(tag, pin[i], exp_pin(i));
            chk(tag, rd[i], m_en[i]);
        end
    endtask

    initial begin
        int seed;
        seed    = $urandom(32'h5A17);
        rst     = 3'b111;
        sync_in = 1'b0;
        sample  = '0;
        cfg_we  = 1'b0;
        cfg_wd  = 1'b0;

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            sample = SW'($urandom);
            tick("R1");
        end

        // staggered release gives three different phases
        rst[0] = 1'b0;
        repeat (5) tick("R1");
        rst[1] = 1'b0;
        repeat (6) tick("R2");
        rst[2] = 1'b0;
        cfg_we = 1'b1;
        cfg_wd = 1'b1;
        tick("R7");
        cfg_we = 1'b0;
        repeat (70) tick("R2/R5");

        // one shared rising edge, then held high
        sync_in = 1'b1;
        tick("R3");
        repeat (45) tick("R4");
        sync_in = 1'b0;
        for (int k = 0; k < 70; k++) begin
            tick("R10");
            chk("R10", pin[1], pin[0]);
            chk("R10", pin[2], pin[0]);
        end

        // periodic alignment every 64 cycles with long high level
        for (int p = 0; p < 5; p++) begin
            sync_in = 1'b1;
            repeat (20) tick("R6");
            sync_in = 1'b0;
            repeat (44) tick("R6");
        end
        // periodic single-cycle pulses every 32 cycles
        for (int p = 0; p < 6; p++) begin
            sync_in = 1'b1;
            tick("R6");
            sync_in = 1'b0;
            repeat (31) tick("R6");
        end

        // held high through reset release of copy 0
        rst[0]  = 1'b1;
        sync_in = 1'b1;
        repeat (2) tick("R1");
        rst[0] = 1'b0;
        cfg_we = 1'b1;
        cfg_wd = 1'b1;
        tick("R9");
        cfg_we = 1'b0;
        repeat (40) tick("R9");
        sync_in = 1'b0;
        tick("R9");

        // sample path
        cfg_we = 1'b1;
        cfg_wd = 1'b0;
        tick("R7");
        cfg_we = 1'b0;
        for (int k = 0; k < 40; k++) begin
            sample  = SW'($urandom);
            sync_in = ($urandom % 5 == 0);
            tick("R8");
        end

        // random mix: writes and alignment edges may coincide
        for (int k = 0; k < 2500; k++) begin
            sample = SW'($urandom);
            if ($urandom % 8 == 0) sync_in = ~sync_in;
            cfg_we = ($urandom % 16 == 0);
            cfg_wd = ($urandom % 4 != 0);
            tick("R7/R10");
            if (rd == 3'b111) begin
                chk("R10", pin[1], pin[0]);
                chk("R10", pin[2], pin[0]);
            end
        end
        cfg_we = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule